// File: doc/BRIEF.md
# Overwriting Receive Byte Ring Buffer

This block stores bytes from a serial receiver until a consumer pulls them out. Each arriving byte is written at a head position and each pull takes the byte at a tail position. Both positions step forward and fold back to slot zero at the end of the active region. The active region is a run-time length, taken from a configuration input when the buffer is started. It may be any value from two up to the depth fixed at build time.

Occupancy is derived from the two positions. One slot is always left empty, so that a full buffer and an empty buffer can be told apart. When a byte arrives while the buffer is full, the block does not drop the new byte. It discards the oldest stored byte, stores the new one and raises a one-cycle overrun pulse. A consumer that wants N bytes asserts its pull request for N cycles. It receives as many bytes as are stored, up to N. Pulls made while the buffer is empty return nothing.

Top module: `rx_ring_buf`

## Requirements
- R1: After reset, level_o is 0, empty_o is 1, and full_o, rd_valid_o and overrun_o are 0. The buffer is stopped until start_i is pulsed.
- R2: While running, level_o equals the number of stored bytes: it rises by one per accepted write and falls by one per accepted pull. This holds as the positions fold back past the end of the active region.
- R3: full_o is 1 exactly when level_o equals the active size minus one. level_o never exceeds that value.
- R4: A write to a full buffer with no pull in the same cycle drops the oldest stored byte and stores the new one. level_o stays at size minus one, and overrun_o is 1 for exactly the following cycle.
- R5: A write and a pull in the same cycle on a full buffer apply the pull first. The oldest byte is returned, nothing is evicted, overrun_o stays 0 and full_o stays 1.
- R6: A pull while level_o is 0 leaves rd_valid_o at 0 in the next cycle, and level_o stays unchanged.
- R7: An accepted pull sets rd_valid_o in the next cycle, with rd_data_o holding the oldest stored byte. Bytes come out in arrival order.
- R8: start_i samples size_cfg_i, clears both positions and starts the buffer. A value below 2 is taken as 2, and a value above MAX_DEPTH is taken as MAX_DEPTH.
- R9: stop_i clears both positions and stops the buffer. While the buffer is stopped, writes and pulls have no effect.
- R10: If start_i and stop_i are high in the same cycle, start_i wins. A write or pull presented in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse: load size, clear positions, run |
| stop_i | input | 1 | Stop pulse: clear positions, halt |
| size_cfg_i | input | SZ_W | Requested active size, sampled on start |
| wr_valid_i | input | 1 | Received byte present this cycle |
| wr_data_i | input | DATA_W | Received byte |
| rd_req_i | input | 1 | Consumer pulls one byte |
| rd_valid_o | output | 1 | rd_data_o carries a pulled byte |
| rd_data_o | output | DATA_W | Pulled byte |
| level_o | output | SZ_W | Number of stored bytes |
| full_o | output | 1 | Level equals size minus one |
| empty_o | output | 1 | Level is zero |
| overrun_o | output | 1 | One-cycle pulse after an eviction |

## Verification
The bench builds the block with MAX_DEPTH of 8, which gives a four-bit size input. It sweeps every value that input can take, so both clamping limits and every legal size are reached. With capacities this small, each size can be filled past full and drained past empty within a few cycles. The fold-back of both positions, eviction, and a full buffer with a pull in the same cycle then occur many times at every size. A reference queue in the bench predicts each output on every cycle.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [1:0] {
    CTL_NONE  = 2'd0,
    CTL_START = 2'd1,
    CTL_STOP  = 2'd2
  } rb_ctl_e;
endpackage

// File: rtl/rb_ptr.sv
module rb_ptr #(
  parameter int PTR_W = 3,
  parameter int SZ_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [SZ_W-1:0]  size_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [SZ_W-1:0]  inc;

  assign inc = {{(SZ_W-PTR_W){1'b0}}, ptr_q} + {{(SZ_W-1){1'b0}}, 1'b1};

  always_comb begin
    ptr_d = ptr_q;
    if (clr_i)      ptr_d = '0;
    else if (adv_i) ptr_d = (inc == size_i) ? '0 : inc[PTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ptr_q <= '0;
    else if (clr_i || adv_i)   ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R2
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {{(SZ_W-PTR_W){1'b0}}, ptr_q} < size_i);
endmodule

// File: rtl/rb_level.sv
module rb_level #(
  parameter int PTR_W = 3,
  parameter int SZ_W  = 4
) (
  input  logic [PTR_W-1:0] head_i,
  input  logic [PTR_W-1:0] tail_i,
  input  logic [SZ_W-1:0]  size_i,
  output logic [SZ_W-1:0]  level_o
);
  logic [SZ_W-1:0] head_x, tail_x;

  assign head_x = {{(SZ_W-PTR_W){1'b0}}, head_i};
  assign tail_x = {{(SZ_W-PTR_W){1'b0}}, tail_i};

  always_comb begin
    if (tail_x > head_x) level_o = head_x + size_i - tail_x;
    else                 level_o = head_x - tail_x;
  end
endmodule

// File: rtl/rb_store.sv
module rb_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/rx_ring_buf.sv
module rx_ring_buf
  import rb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int MAX_DEPTH = 8,
  localparam int PTR_W    = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1,
  localparam int SZ_W     = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [SZ_W-1:0]   size_cfg_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [SZ_W-1:0]   level_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              overrun_o
);
  localparam logic [SZ_W-1:0] SZ_MIN = SZ_W'(2);
  localparam logic [SZ_W-1:0] SZ_MAX = SZ_W'(MAX_DEPTH);

  rb_ctl_e           ctl;
  logic              run_q, run_d;
  logic [SZ_W-1:0]   size_q, size_d;
  logic [PTR_W-1:0]  head, tail;
  logic              clr, wr_fire, rd_fire, evict;
  logic [DATA_W-1:0] mem_rdata;
  logic              rd_valid_q, ovr_q;
  logic [DATA_W-1:0] rd_data_q;

  always_comb begin
    if (start_i)     ctl = CTL_START;
    else if (stop_i) ctl = CTL_STOP;
    else             ctl = CTL_NONE;
  end

  // Size clamp and run state, next-state
  always_comb begin
    run_d  = run_q;
    size_d = size_q;
    unique case (ctl)
      CTL_START: begin
        run_d = 1'b1;
        if (size_cfg_i < SZ_MIN)      size_d = SZ_MIN;
        else if (size_cfg_i > SZ_MAX) size_d = SZ_MAX;
        else                          size_d = size_cfg_i;
      end
      CTL_STOP: run_d = 1'b0;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      size_q <= SZ_MAX;
    end else if (ctl != CTL_NONE) begin
      run_q  <= run_d;
      size_q <= size_d;
    end
  end

  assign clr     = (ctl != CTL_NONE);
  assign wr_fire = run_q && !clr && wr_valid_i;
  assign rd_fire = run_q && !clr && rd_req_i && !empty_o;
  // Pull is applied before the write, so a simultaneous pull removes the need to evict
  assign evict   = wr_fire && full_o && !rd_fire;

  rb_ptr #(.PTR_W(PTR_W), .SZ_W(SZ_W)) u_head (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .adv_i(wr_fire),
    .size_i(size_q), .ptr_o(head)
  );

  rb_ptr #(.PTR_W(PTR_W), .SZ_W(SZ_W)) u_tail (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .adv_i(rd_fire || evict),
    .size_i(size_q), .ptr_o(tail)
  );

  rb_level #(.PTR_W(PTR_W), .SZ_W(SZ_W)) u_level (
    .head_i(head), .tail_i(tail), .size_i(size_q), .level_o(level_o)
  );

  rb_store #(.DATA_W(DATA_W), .DEPTH(MAX_DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .we_i(wr_fire), .waddr_i(head), .wdata_i(wr_data_i),
    .raddr_i(tail), .rdata_o(mem_rdata)
  );

  assign full_o  = (level_o == size_q - SZ_W'(1));
  assign empty_o = (level_o == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      rd_valid_q <= rd_fire;
      ovr_q      <= evict;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data_q <= '0;
    else if (rd_fire) rd_data_q <= mem_rdata;
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
  assign overrun_o  = ovr_q;

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_o < size_q);

  // R4
  evict_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start_i && !stop_i && wr_valid_i && !rd_req_i && full_o)
      |=> (overrun_o && full_o));

  // R5
  full_pull_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start_i && !stop_i && wr_valid_i && rd_req_i && full_o)
      |=> (!overrun_o && full_o && rd_valid_o));

  // R6
  empty_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && empty_o && !wr_valid_i) |=> (!rd_valid_o && empty_o));

  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (empty_o && !overrun_o));

  // R9
  stopped_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_i) |=> (empty_o && !rd_valid_o));
endmodule

// File: tb/tb_rx_ring_buf.sv
`timescale 1ns/1ps
module tb_rx_ring_buf;
  localparam int MAXD = 8;
  localparam int SZW  = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start_i, stop_i, wr_valid_i, rd_req_i;
  logic [SZW-1:0] size_cfg_i;
  logic [7:0]     wr_data_i;
  logic           rd_valid_o, full_o, empty_o, overrun_o;
  logic [7:0]     rd_data_o;
  logic [SZW-1:0] level_o;

  int tests = 0;
  int fails = 0;
  int q[$];
  int msize = MAXD;
  bit mrun  = 1'b0;

  always #2.5 clk = ~clk;

  rx_ring_buf #(.DATA_W(8), .MAX_DEPTH(MAXD)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .size_cfg_i(size_cfg_i), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
    .rd_req_i(rd_req_i), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .level_o(level_o), .full_o(full_o), .empty_o(empty_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit st, input bit sp, input int sz,
                     input bit wr, input int wd, input bit rd);
    string tag;
    bit    rd_ok, ov;
    int    popped;
    int    cap;
    rd_ok  = 1'b0;
    ov     = 1'b0;
    popped = 0;
    cap    = msize - 1;
    if (st && sp)                         tag = "R10";
    else if (st)                          tag = "R8";
    else if (sp || !mrun)                 tag = "R9";
    else if (wr && !rd && q.size() == cap) tag = "R4";
    else if (wr && rd && q.size() == cap)  tag = "R5";
    else if (rd && q.size() == 0)         tag = "R6";
    else if (rd)                          tag = "R7";
    else                                  tag = "R2";
    start_i    = st;
    stop_i     = sp;
    size_cfg_i = SZW'(sz);
    wr_valid_i = wr;
    wr_data_i  = 8'(wd);
    rd_req_i   = rd;
    if (st) begin
      msize = (sz < 2) ? 2 : ((sz > MAXD) ? MAXD : sz);
      q.delete();
      mrun = 1'b1;
    end else if (sp) begin
      q.delete();
      mrun = 1'b0;
    end else if (mrun) begin
      if (rd && q.size() > 0) begin
        rd_ok  = 1'b1;
        popped = q.pop_front();
      end
      if (wr) begin
        if (q.size() == msize - 1) begin
          void'(q.pop_front());
          ov = 1'b1;
        end
        q.push_back(wd & 255);
      end
    end
    @(posedge clk);
    #1;
    chk(rd_valid_o == rd_ok, tag, "rd_valid", int'(rd_valid_o), int'(rd_ok));
    if (rd_ok) chk(int'(rd_data_o) == popped, tag, "rd_data", int'(rd_data_o), popped);
    chk(overrun_o == ov, tag, "overrun", int'(overrun_o), int'(ov));
    chk(int'(level_o) == q.size(), tag, "level", int'(level_o), q.size());
    // R3
    chk(full_o == (q.size() == msize - 1), "R3", "full", int'(full_o), int'(q.size() == msize - 1));
    chk(empty_o == (q.size() == 0), tag, "empty", int'(empty_o), int'(q.size() == 0));
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start_i = 0; stop_i = 0; size_cfg_i = '0;
    wr_valid_i = 0; wr_data_i = '0; rd_req_i = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    #1;
    // R1
    chk(level_o == 0, "R1", "level", int'(level_o), 0);
    chk(empty_o == 1, "R1", "empty", int'(empty_o), 1);
    chk(full_o == 0, "R1", "full", int'(full_o), 0);
    chk(rd_valid_o == 0, "R1", "rd_valid", int'(rd_valid_o), 0);
    chk(overrun_o == 0, "R1", "overrun", int'(overrun_o), 0);

    // R9: stopped after reset, writes and pulls ignored
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, i, i[0]);

    // R8/R2/R4/R6/R7: every size code, overfill then overdrain
    for (int sz = 0; sz < 16; sz++) begin
      cyc(1, 0, sz, 1, 99, 1);
      for (int i = 0; i < msize + 3; i++) cyc(0, 0, 0, 1, sz * 16 + i, 0);
      for (int i = 0; i < msize + 2; i++) cyc(0, 0, 0, 0, 0, 1);
    end

    // R5/R4/R9: full buffer with simultaneous pull and write, then evict, then stop
    for (int sz = 2; sz <= MAXD; sz++) begin
      cyc(1, 0, sz, 0, 0, 0);
      for (int i = 0; i < sz - 1; i++) cyc(0, 0, 0, 1, 100 + i, 0);
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 200 + i, 1);
      cyc(0, 0, 0, 1, 77, 0);
      cyc(0, 0, 0, 1, 78, 0);
      cyc(0, 1, 0, 1, 79, 1);
      cyc(0, 0, 0, 1, 80, 1);
      cyc(0, 0, 0, 0, 0, 1);
    end

    // R10: start and stop together, with traffic in that cycle
    cyc(1, 1, 4, 1, 5, 1);
    cyc(0, 0, 0, 1, 6, 0);
    cyc(1, 1, 6, 1, 7, 0);
    cyc(0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);

    // R2/R7: long mixed traffic with many fold-backs
    for (int sz = 2; sz <= MAXD; sz++) begin
      cyc(1, 0, sz, 0, 0, 0);
      for (int i = 0; i < 120; i++)
        cyc(0, 0, 0, (i % 3) != 0, i * 7 + sz, ((i / 2) % 3) != 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule